// File: doc/BRIEF.md
# Outgoing Packet Framer

This block turns a stream of 16-bit words into framed packets for a pair of byte-wide block encoders that sit behind a transceiver-style data/control-flag interface. Each packet is one control word marking the start, then exactly 239 data words. Each data word carries one symbol for each of the two encoder lanes. Between packets the line carries comma idle words, so the far end can keep its byte alignment.

Data words come either from a show-ahead input FIFO or from an internal counter-based pattern generator. A configuration input selects the source. A second configuration input selects the trigger. In automatic mode a block is sent whenever the encoder is ready and a whole block of data is on hand. In request mode a one-cycle software pulse arms the framer for a single block. The framer never starts a block unless the encoder signals ready. Once a block has started it runs to the end without a break. The outputs are registered.

Top module: `pkt_framer`

## Requirements
- R1: While rst_n is low, tx_data is 0xBCBC, tx_is_k is 2'b11 and fifo_rd_en is 0.
- R2: Whenever no packet word is being emitted, the output word is the comma idle 0xBCBC (K28.5 in both bytes) with tx_is_k = 2'b11.
- R3: A packet is the start word 0xFBFB with tx_is_k = 2'b11, followed on the next 239 consecutive cycles by data words with tx_is_k = 2'b00. Flag bits are 1 only on comma and start words.
- R4: A block is started only from a cycle in which enc_ready is 1 and no block is in progress. The start word then appears on the following cycle, and enc_ready is not consulted again until the block ends.
- R5: With cfg_auto_send = 1, a block starts whenever the framer is idle, enc_ready is 1 and data is available. Data is available when cfg_pattern_src = 1 or fifo_level >= 239. Blocks may follow back to back with no idle word between them.
- R6: With cfg_auto_send = 0, a sw_send_req pulse seen while idle is held until a block starts, and each held request yields exactly one block. Pulses are dropped in three cases: during a block, in the cycle the block starts, or while cfg_auto_send = 1.
- R7: With the FIFO as source, fifo_rd_en is 1 in exactly the 239 cycles in which a block's data is taken. Each data word equals the fifo_rd_data presented in the cycle before it appears, and fifo_rd_en is never 1 when fifo_level is 0.
- R8: With the pattern generator as source, the data words are successive values of a 16-bit counter. The counter is 0 after reset, wraps modulo 2^16 and continues across blocks, and fifo_rd_en stays 0.
- R9: cfg_pattern_src is sampled when a block starts. Changing it during a block has no effect on that block's data or FIFO reads.
- R10: With the FIFO as source and fifo_level < 239, no block starts; a held request stays held until enough data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pattern_src | input | 1 | 1: pattern generator is the data source, 0: input FIFO |
| cfg_auto_send | input | 1 | 1: automatic sending, 0: send on software request |
| sw_send_req | input | 1 | One-cycle software send request |
| enc_ready | input | 1 | Encoder can accept a new block |
| fifo_rd_data | input | 16 | Show-ahead FIFO head word |
| fifo_level | input | 10 | Number of words held in the FIFO |
| fifo_rd_en | output | 1 | Pops the FIFO head at the clock edge |
| tx_data | output | 16 | Outgoing word |
| tx_is_k | output | 2 | Per-byte control-character flags |

## Verification
Two events can fall in the same cycle: a software request pulse, and the start of a block that consumes an earlier held request. The bench provokes this by pulsing the request in the cycle the block starts. It then counts start words over the following cycles: exactly one block must result. Two other collisions are also exercised: pulses during the last data cycles of a block, and source changes in mid-block. A cycle-accurate model in the bench predicts every output word, flag pair and FIFO read from the requirements alone.

// File: rtl/pkt_frm_pkg.sv
package pkt_frm_pkg;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_BODY = 1'b1
  } frm_state_t;

  localparam logic [7:0] K_IDLE_BYTE = 8'hBC;
  localparam logic [7:0] K_SOP_BYTE  = 8'hFB;

  function automatic logic level_covers(input int unsigned level, input int unsigned need);
    return level >= need;
  endfunction

  function automatic logic may_start(input logic busy, input logic ready,
                                     input logic avail, input logic armed);
    return !busy && ready && avail && armed;
  endfunction

endpackage

// File: rtl/pkt_frm_trigger.sv
module pkt_frm_trigger #(
  parameter int LVL_W     = 10,
  parameter int BLK_WORDS = 239
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_auto,
  input  logic             cfg_pat,
  input  logic             sw_req,
  input  logic             enc_ready,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             busy,
  output logic             start,
  output logic             req_pend
);
  import pkt_frm_pkg::*;

  logic data_avail;
  logic armed;

  assign data_avail = cfg_pat | level_covers(32'(fifo_level), BLK_WORDS);
  assign armed      = cfg_auto | req_pend;
  assign start      = may_start(busy, enc_ready, data_avail, armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_pend <= 1'b0;
    end else if (start) begin
      req_pend <= 1'b0;
    end else if (!busy && sw_req && !cfg_auto) begin
      req_pend <= 1'b1;
    end
  end

  // R6: a request cannot become held while a block runs
  p_req_ignored_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !req_pend |=> !req_pend);

  // R6: starting a block consumes the held request, same-cycle pulse included
  p_req_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_pend);

endmodule

// File: rtl/pkt_frm_patgen.sv
module pkt_frm_patgen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] pat_word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_word <= '0;
    end else if (adv) begin
      pat_word <= pat_word + 1'b1;
    end
  end

  // R8: each consumed pattern word is followed by its successor
  p_pat_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> pat_word == W'($past(pat_word) + 1'b1));

  // R8: the counter holds while no pattern word is consumed
  p_pat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pat_word));

endmodule

// File: rtl/pkt_frm_seq.sv
module pkt_frm_seq #(
  parameter int BLK_WORDS = 239
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cfg_pat,
  output logic busy,
  output logic blk_src
);
  import pkt_frm_pkg::*;

  localparam int CNT_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_WORDS - 1);

  frm_state_t       st;
  logic [CNT_W-1:0] cnt;

  assign busy = (st == FS_BODY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= FS_IDLE;
      cnt     <= '0;
      blk_src <= 1'b0;
    end else begin
      case (st)
        FS_IDLE: if (start) begin
          st      <= FS_BODY;
          cnt     <= '0;
          blk_src <= cfg_pat;
        end
        FS_BODY: if (cnt == LAST) begin
          st <= FS_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  // R9: the source chosen at block start is held through the block
  p_src_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(blk_src));

  // R3: the word counter never runs past the block length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int DATA_W     = 16,
  parameter int BLK_WORDS  = 239,
  parameter int FIFO_DEPTH = 512,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int LANES      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pattern_src,
  input  logic              cfg_auto_send,
  input  logic              sw_send_req,
  input  logic              enc_ready,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_rd_en,
  output logic [DATA_W-1:0] tx_data,
  output logic [LANES-1:0]  tx_is_k
);
  import pkt_frm_pkg::*;

  logic              start;
  logic              req_pend;
  logic              busy;
  logic              blk_src;
  logic              pat_adv;
  logic [DATA_W-1:0] pat_word;
  logic [DATA_W-1:0] comma_w;
  logic [DATA_W-1:0] sop_w;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign comma_w[i*8 +: 8] = K_IDLE_BYTE;
    assign sop_w[i*8 +: 8]   = K_SOP_BYTE;
  end

  pkt_frm_trigger #(.LVL_W(LVL_W), .BLK_WORDS(BLK_WORDS)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_auto   (cfg_auto_send),
    .cfg_pat    (cfg_pattern_src),
    .sw_req     (sw_send_req),
    .enc_ready  (enc_ready),
    .fifo_level (fifo_level),
    .busy       (busy),
    .start      (start),
    .req_pend   (req_pend)
  );

  pkt_frm_seq #(.BLK_WORDS(BLK_WORDS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cfg_pat (cfg_pattern_src),
    .busy    (busy),
    .blk_src (blk_src)
  );

  assign pat_adv    = busy & blk_src;
  assign fifo_rd_en = busy & ~blk_src;

  pkt_frm_patgen #(.W(DATA_W)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (pat_adv),
    .pat_word (pat_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data <= comma_w;
      tx_is_k <= '1;
    end else if (busy) begin
      tx_data <= blk_src ? pat_word : fifo_rd_data;
      tx_is_k <= '0;
    end else if (start) begin
      tx_data <= sop_w;
      tx_is_k <= '1;
    end else begin
      tx_data <= comma_w;
      tx_is_k <= '1;
    end
  end

  // R2: idle with no start gives a comma word next cycle
  p_idle_comma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> (tx_data == comma_w && tx_is_k == '1));

  // R3: every cycle inside a block emits a data word with clear flags
  p_data_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> tx_is_k == '0);

  // R3: a start word on the line means the block body is running
  p_sop_then_body_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_is_k == '1 && tx_data == sop_w) |-> busy);

  // R4: a block only begins after the encoder showed ready
  p_start_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enc_ready));

  // R7: the FIFO is never popped while empty
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> fifo_level != '0);

endmodule

// File: tb/pkt_framer_test.sv
module pkt_framer_test;
  localparam int BLK = 239;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_pattern_src = 1'b0;
  logic        cfg_auto_send = 1'b0;
  logic        sw_send_req = 1'b0;
  logic        enc_ready = 1'b0;
  logic [15:0] fifo_rd_data;
  logic [9:0]  fifo_level;
  logic        fifo_rd_en;
  logic [15:0] tx_data;
  logic [1:0]  tx_is_k;

  always #4 clk = ~clk;

  // bench FIFO
  logic [15:0] fifo_mem [0:1023];
  logic [9:0]  fifo_ptr = '0;
  int          fifo_cnt = 0;
  bit          pop_pending = 0;
  assign fifo_rd_data = fifo_mem[fifo_ptr];
  assign fifo_level   = 10'(fifo_cnt);

  pkt_framer uut (
    .clk(clk), .rst_n(rst_n), .cfg_pattern_src(cfg_pattern_src),
    .cfg_auto_send(cfg_auto_send), .sw_send_req(sw_send_req),
    .enc_ready(enc_ready), .fifo_rd_data(fifo_rd_data),
    .fifo_level(fifo_level), .fifo_rd_en(fifo_rd_en),
    .tx_data(tx_data), .tx_is_k(tx_is_k)
  );

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  // model state
  bit          m_inblk = 0;
  int          m_cnt = 0;
  bit          m_pend = 0;
  logic [15:0] m_pat = '0;
  bit          m_src = 0;
  logic [15:0] exp_data = 16'hBCBC;
  logic [1:0]  exp_k = 2'b11;
  string       exp_tag = "R2";
  int          sop_count = 0;
  bit          nxt_pat = 0;
  bit          nxt_auto = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  function automatic bit avail_now();
    return cfg_pattern_src || (fifo_cnt >= BLK);
  endfunction

  task automatic model_step();
    bit go;
    go = !m_inblk && enc_ready && avail_now() && (cfg_auto_send || m_pend);
    pop_pending = 0;
    if (m_inblk) begin
      exp_k = 2'b00;
      if (m_src) begin
        exp_data = m_pat;
        m_pat    = m_pat + 16'd1;
        exp_tag  = cfg_pattern_src ? "R8" : "R9";
      end else begin
        exp_data    = fifo_mem[fifo_ptr];
        pop_pending = 1;
        exp_tag     = cfg_pattern_src ? "R9" : "R7";
      end
      m_cnt++;
      if (m_cnt == BLK) m_inblk = 0;
    end else if (go) begin
      exp_data = 16'hFBFB;
      exp_k    = 2'b11;
      m_inblk  = 1;
      m_cnt    = 0;
      m_src    = cfg_pattern_src;
      m_pend   = 0;
      exp_tag  = cfg_auto_send ? "R5" : "R6";
      sop_count++;
    end else begin
      exp_data = 16'hBCBC;
      exp_k    = 2'b11;
      if (!enc_ready && avail_now() && (cfg_auto_send || m_pend)) exp_tag = "R4";
      else if (m_pend && !avail_now()) exp_tag = "R10";
      else exp_tag = "R2";
      if (sw_send_req && !cfg_auto_send) m_pend = 1;
    end
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      logic [9:0] idx;
      idx = fifo_ptr + 10'(fifo_cnt);
      fifo_mem[idx] = 16'($urandom);
      fifo_cnt++;
    end
  endtask

  task automatic cyc(input bit req, input bit rdy, input int pushes);
    @(negedge clk);
    chk(tx_data == exp_data && tx_is_k == exp_k, exp_tag,
        {14'd0, tx_is_k, tx_data}, {14'd0, exp_k, exp_data});
    chk(fifo_rd_en == (m_inblk && !m_src), "R7", 32'(fifo_rd_en),
        32'(m_inblk && !m_src));
    if (pop_pending) begin
      fifo_ptr = fifo_ptr + 10'd1;
      fifo_cnt--;
    end
    push(pushes);
    cfg_pattern_src = nxt_pat;
    cfg_auto_send   = nxt_auto;
    sw_send_req     = req;
    enc_ready       = rdy;
    model_step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", wd);
      finish_run();
    end
  end

  initial begin
    int s0, base, lvl0;
    s0 = $urandom(32'h5EED_0042);
    for (int i = 0; i < 1024; i++) fifo_mem[i] = '0;

    // reset state, R1
    repeat (3) begin
      @(negedge clk);
      chk(tx_data == 16'hBCBC && tx_is_k == 2'b11, "R1",
          {14'd0, tx_is_k, tx_data}, {14'd0, 2'b11, 16'hBCBC});
      chk(fifo_rd_en == 1'b0, "R1", 32'(fifo_rd_en), 32'd0);
    end
    rst_n = 1'b1;
    model_step();

    // R4: auto, pattern source, encoder not ready
    nxt_auto = 1; nxt_pat = 1;
    repeat (40) cyc(0, 0, 0);
    chk(sop_count == 0, "R4", 32'(sop_count), 32'd0);

    // R5 / R8 / R3: back-to-back automatic blocks
    base = sop_count;
    repeat (700) cyc(0, 1, 0);
    chk(sop_count - base >= 2, "R5", 32'(sop_count - base), 32'd2);

    // R10: request mode, FIFO short of a block
    nxt_auto = 0; nxt_pat = 0;
    while (m_inblk) cyc(0, 1, 0);
    cyc(0, 1, 0);
    base = sop_count;
    cyc(1, 1, 0);
    repeat (60) cyc(0, 1, 3);
    chk(sop_count == base, "R10", 32'(sop_count), 32'(base));
    repeat (300) cyc(0, 1, (fifo_cnt < 300) ? 3 : 0);
    chk(sop_count == base + 1, "R10", 32'(sop_count), 32'(base + 1));

    // R6: pulse collides with block start, pulses during block
    nxt_pat = 1;
    while (m_inblk) cyc(0, 1, 0);
    cyc(0, 1, 0);
    base = sop_count;
    cyc(1, 1, 0);
    cyc(1, 1, 0);
    repeat (200) cyc(0, 1, 0);
    cyc(1, 1, 0);
    cyc(1, 1, 0);
    while (m_inblk) cyc(0, 1, 0);
    repeat (100) cyc(0, 1, 0);
    chk(sop_count == base + 1, "R6", 32'(sop_count), 32'(base + 1));

    // R6: pulses in auto mode are not held
    nxt_auto = 1; nxt_pat = 0;
    repeat (5) cyc(1, 0, 0);
    nxt_auto = 0;
    cyc(0, 1, 0);
    base = sop_count;
    repeat (20) cyc(0, 1, 0);
    chk(sop_count == base, "R6", 32'(sop_count), 32'(base));

    // R9: source flipped in mid-block
    nxt_pat = 0;
    while (fifo_cnt < 300) cyc(0, 1, 5);
    lvl0 = fifo_cnt;
    cyc(1, 1, 0);
    repeat (20) cyc(0, 1, 0);
    nxt_pat = 1;
    while (m_inblk) cyc(0, 1, 0);
    repeat (5) cyc(0, 1, 0);
    chk(lvl0 - fifo_cnt == BLK, "R9", 32'(lvl0 - fifo_cnt), 32'(BLK));

    // random mix
    for (int n = 0; n < 20000; n++) begin
      if ($urandom % 400 == 0) nxt_pat = ~nxt_pat;
      if ($urandom % 500 == 0) nxt_auto = ~nxt_auto;
      cyc(($urandom % 40) == 0, ($urandom % 8) != 0,
          (fifo_cnt < 480) ? int'($urandom % 4) : 0);
    end
    chk(sop_count > 20, "R5", 32'(sop_count), 32'd20);

    finish_run();
  end
endmodule